// File: doc/BRIEF.md
# Interleaved Memory Data Multiplexer Slice

This block sits between several parallel DRAM interleaves and one narrower host data path. A cache line is held across the interleaves, one 72-bit word per interleave. The block turns that line into a burst of words on the host port, and collects a burst from the host to turn it back into a line. One slice carries 36 bits of each word. Two slices placed side by side cover the full 72-bit word, which is 64 data bits and 8 check bits. Each interleave port of a slice is split into two 18-bit lanes.

A read begins on a start strobe with the direction input low. In that cycle the block latches every active interleave port at once. It then presents the stored words on the host port, one per clock, starting at interleave 0. A write begins on the same strobe with the direction input high. The block takes one host word per clock into the register of each interleave in turn. Once the last active register holds its word, it drives all active interleaves for one cycle and flags write-ready. The block supports two modes. In 4-way mode a line uses four interleaves. In 2-way mode it uses only interleaves 0 and 1, and the burst is two words long. The block never drives both sides in the same cycle. A one-cycle done pulse marks the end of every burst.

Top module: `ilv_mux_slice`

## Requirements
- R1: While reset is high, and in the first cycle after it, `host_oe`, every bit of `dram_oe`, `wr_ready` and `burst_done` are low.
- R2: A read captures all active interleave ports on the clock edge at which `start` is seen with `dir_write` low. Interleave i sits at `dram_rd_data[i*36 +: 36]`, with lane 0 in bits 17:0 and lane 1 in bits 35:18. Later changes on `dram_rd_data` do not alter the burst.
- R3: In 4-way mode (`two_way_mode`=0), the four cycles after a read start show `host_oe` high. `host_dout` carries interleave 0, 1, 2 and 3 in that order, with both lanes in the same bit positions as on the DRAM port.
- R4: In 2-way mode (`two_way_mode`=1), a read burst has exactly two host cycles, carrying interleaves 0 and 1.
- R5: A 4-way write takes `host_din` in the start cycle and the three cycles after it, as interleaves 0 to 3. The next cycle shows `dram_oe`=4'b1111 and `wr_ready` high for one cycle, with word i on `dram_wr_data[i*36 +: 36]`.
- R6: A 2-way write takes two host words. In its drive cycle `dram_oe`=4'b0011, and the fields for interleaves 2 and 3 are zero.
- R7: `host_oe` and any bit of `dram_oe` are never high in the same cycle.
- R8: When no burst is running, `host_oe` and `dram_oe` stay low.
- R9: `burst_done` is high for exactly one cycle: the cycle after the last host word of a read, or the cycle after the drive cycle of a write.
- R10: A `start` seen while a burst is running is ignored. A `start` in the cycle `burst_done` is high is accepted.
- R11: Mode and direction are sampled only with an accepted `start`. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| two_way_mode | input | 1 | 1 selects 2-way interleave, 0 selects 4-way |
| dir_write | input | 1 | 1 = host to DRAM, 0 = DRAM to host; sampled with start |
| start | input | 1 | Begins a burst when idle |
| dram_rd_data | input | 144 | Words read from interleaves 0..3, 36 bits each |
| dram_wr_data | output | 144 | Words to write to interleaves 0..3 |
| dram_oe | output | 4 | Per-interleave drive enable toward DRAM |
| host_din | input | 36 | Word from the host during a write |
| host_dout | output | 36 | Word to the host during a read |
| host_oe | output | 1 | Drive enable toward the host |
| wr_ready | output | 1 | Write line fully collected and driven |
| burst_done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench runs reads and writes in both modes, each with a distinct value per interleave and per lane. This shows whether words come out in the right order, whether the lanes stay in place, and whether the 2-way mode stops after two words. In reads, the DRAM inputs change on every cycle after the start, which tells a single capture apart from a pass-through. In writes, the host words are distinct, which shows that each word lands on its own interleave. The bench also raises start during a burst, starts a new burst in the done cycle, and toggles mode and direction mid-burst. A randomized mix of back-to-back and spaced bursts tests how the mutual-exclusion and done-pulse rules hold up across transitions.

// File: rtl/ilv_mux_pkg.sv
package ilv_mux_pkg;

    parameter int unsigned ILV_MAX   = 4;
    parameter int unsigned LANE_W    = 18;
    parameter int unsigned LANES     = 2;
    parameter int unsigned PORT_W    = LANE_W * LANES;
    parameter int unsigned IDX_W     = $clog2(ILV_MAX);
    parameter int unsigned BUS_W     = PORT_W * ILV_MAX;
    parameter int unsigned TWO_WAY_N = 2;

    typedef logic [LANE_W-1:0] lane_t;

    // lane 1 is the upper half of a slice word
    typedef struct packed {
        lane_t hi;
        lane_t lo;
    } port_word_t;

    typedef port_word_t [ILV_MAX-1:0] line_t;
    typedef logic [IDX_W-1:0]         ilv_idx_t;
    typedef logic [ILV_MAX-1:0]       ilv_mask_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_READ = 2'd1,
        SQ_FILL = 2'd2,
        SQ_PUSH = 2'd3
    } seq_state_t;

    function automatic ilv_idx_t last_index(input logic two_way);
        return two_way ? ilv_idx_t'(TWO_WAY_N - 1) : ilv_idx_t'(ILV_MAX - 1);
    endfunction

    function automatic ilv_mask_t active_mask(input logic two_way);
        ilv_mask_t m;
        for (int i = 0; i < ILV_MAX; i++) begin
            m[i] = two_way ? (i < TWO_WAY_N) : 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl
    import ilv_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       dir_write,
    input  logic       two_way_mode,
    output seq_state_t state,
    output ilv_idx_t   idx,
    output logic       mode_two_way,
    output logic       cap_en,
    output logic       fill_en,
    output ilv_idx_t   fill_idx,
    output logic       done
);

    seq_state_t state_q;
    ilv_idx_t   idx_q;
    logic       mode_q;
    logic       done_q;
    logic       accept;

    assign accept = (state_q == SQ_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        mode_q  <= two_way_mode;
                        idx_q   <= dir_write ? ilv_idx_t'(1) : '0;
                        state_q <= dir_write ? SQ_FILL : SQ_READ;
                    end
                end
                SQ_READ: begin
                    if (idx_q == last_index(mode_q)) begin
                        state_q <= SQ_IDLE;
                        idx_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SQ_FILL: begin
                    if (idx_q == last_index(mode_q)) begin
                        state_q <= SQ_PUSH;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SQ_PUSH: begin
                    state_q <= SQ_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign state        = state_q;
    assign idx          = idx_q;
    assign mode_two_way = mode_q;
    assign done         = done_q;
    assign cap_en       = accept && !dir_write;
    assign fill_en      = (accept && dir_write) || (state_q == SQ_FILL);
    assign fill_idx     = (state_q == SQ_IDLE) ? '0 : idx_q;

endmodule

// File: rtl/ilv_capture_bank.sv
module ilv_capture_bank
    import ilv_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_en,
    input  line_t      dram_words,
    input  logic       fill_en,
    input  ilv_idx_t   fill_idx,
    input  port_word_t host_word,
    output line_t      held
);

    for (genvar g = 0; g < ILV_MAX; g++) begin : g_ilv
        port_word_t reg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q <= '0;
            end else if (cap_en) begin
                reg_q <= dram_words[g];
            end else if (fill_en && (fill_idx == ilv_idx_t'(g))) begin
                reg_q <= host_word;
            end
        end

        assign held[g] = reg_q;
    end

endmodule

// File: rtl/ilv_dir_gate.sv
module ilv_dir_gate
    import ilv_mux_pkg::*;
(
    input  seq_state_t state,
    input  ilv_idx_t   idx,
    input  logic       mode_two_way,
    input  line_t      held,
    output port_word_t host_word,
    output logic       host_oe,
    output line_t      dram_words,
    output ilv_mask_t  dram_oe,
    output logic       wr_ready
);

    logic push;

    assign push     = (state == SQ_PUSH);
    assign host_oe  = (state == SQ_READ);
    assign wr_ready = push;
    assign dram_oe  = push ? active_mask(mode_two_way) : '0;

    always_comb begin
        host_word = '0;
        if (host_oe) begin
            host_word = held[idx];
        end
    end

    for (genvar g = 0; g < ILV_MAX; g++) begin : g_out
        assign dram_words[g] = dram_oe[g] ? held[g] : '0;
    end

endmodule

// File: rtl/ilv_mux_slice.sv
module ilv_mux_slice
    import ilv_mux_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 two_way_mode,
    input  logic                 dir_write,
    input  logic                 start,
    input  logic [BUS_W-1:0]     dram_rd_data,
    output logic [BUS_W-1:0]     dram_wr_data,
    output logic [ILV_MAX-1:0]   dram_oe,
    input  logic [PORT_W-1:0]    host_din,
    output logic [PORT_W-1:0]    host_dout,
    output logic                 host_oe,
    output logic                 wr_ready,
    output logic                 burst_done
);

    seq_state_t state;
    ilv_idx_t   idx;
    ilv_idx_t   fill_idx;
    logic       mode_two_way;
    logic       cap_en;
    logic       fill_en;
    line_t      held;
    line_t      dram_in;
    line_t      dram_out;
    port_word_t host_out;

    assign dram_in = line_t'(dram_rd_data);

    ilv_seq_ctrl u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .dir_write    (dir_write),
        .two_way_mode (two_way_mode),
        .state        (state),
        .idx          (idx),
        .mode_two_way (mode_two_way),
        .cap_en       (cap_en),
        .fill_en      (fill_en),
        .fill_idx     (fill_idx),
        .done         (burst_done)
    );

    ilv_capture_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .dram_words (dram_in),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .host_word  (port_word_t'(host_din)),
        .held       (held)
    );

    ilv_dir_gate u_gate (
        .state        (state),
        .idx          (idx),
        .mode_two_way (mode_two_way),
        .held         (held),
        .host_word    (host_out),
        .host_oe      (host_oe),
        .dram_words   (dram_out),
        .dram_oe      (dram_oe),
        .wr_ready     (wr_ready)
    );

    assign host_dout    = host_out;
    assign dram_wr_data = dram_out;

endmodule

// File: rtl/ilv_mux_slice_chk.sv
module ilv_mux_slice_chk
    import ilv_mux_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ILV_MAX-1:0] dram_oe,
    input logic               host_oe,
    input logic               wr_ready,
    input logic               burst_done
);

    // R1: outputs quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!host_oe && dram_oe == '0 && !wr_ready && !burst_done));

    // R7: never both sides driven
    p_one_side_r7: assert property (@(posedge clk) disable iff (rst)
        !(host_oe && (|dram_oe)));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);

    // R9: a read's last host cycle is followed by done
    p_read_end_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(host_oe) |-> burst_done);

    // R5: the DRAM drive lasts one cycle and is followed by done
    p_push_once_r5: assert property (@(posedge clk) disable iff (rst)
        (|dram_oe) |=> (dram_oe == '0 && burst_done));

    // R6: drive enables cover either all four or only the lower two interleaves
    p_mask_shape_r6: assert property (@(posedge clk) disable iff (rst)
        (|dram_oe) |-> (dram_oe == 4'b1111 || dram_oe == 4'b0011));

endmodule

bind ilv_mux_slice ilv_mux_slice_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dram_oe    (dram_oe),
    .host_oe    (host_oe),
    .wr_ready   (wr_ready),
    .burst_done (burst_done)
);

// File: tb/ilv_mux_slice_tb_top.sv
module ilv_mux_slice_tb_top;

    localparam int NI = 4;
    localparam int PW = 36;

    logic            clk = 1'b0;
    logic            rst;
    logic            two_way_mode;
    logic            dir_write;
    logic            start;
    logic [NI*PW-1:0] dram_rd_data;
    logic [NI*PW-1:0] dram_wr_data;
    logic [NI-1:0]    dram_oe;
    logic [PW-1:0]    host_din;
    logic [PW-1:0]    host_dout;
    logic             host_oe;
    logic             wr_ready;
    logic             burst_done;

    always #2.5 clk = ~clk;

    ilv_mux_slice dut_i (
        .clk          (clk),
        .rst          (rst),
        .two_way_mode (two_way_mode),
        .dir_write    (dir_write),
        .start        (start),
        .dram_rd_data (dram_rd_data),
        .dram_wr_data (dram_wr_data),
        .dram_oe      (dram_oe),
        .host_din     (host_din),
        .host_dout    (host_dout),
        .host_oe      (host_oe),
        .wr_ready     (wr_ready),
        .burst_done   (burst_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 read out, 2 collect, 3 drive
    int          m_state = 0;
    int          m_len   = 4;
    int          m_cnt   = 0;
    logic        m_done  = 1'b0;
    logic [PW-1:0] m_rdq[$];
    logic [PW-1:0] m_wr[NI];

    task automatic check(input string what, input logic [NI*PW-1:0] got,
                         input logic [NI*PW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h exp %h", cur_req, what, got, exp);
        end
    endtask

    task automatic model_update();
        logic nd = 1'b0;
        if (rst) begin
            m_state = 0;
            m_rdq.delete();
        end else begin
            case (m_state)
                0: if (start) begin
                    m_len = two_way_mode ? 2 : 4;
                    if (!dir_write) begin
                        m_rdq.delete();
                        for (int i = 0; i < m_len; i++)
                            m_rdq.push_back(dram_rd_data[i*PW +: PW]);
                        m_state = 1;
                    end else begin
                        for (int i = 0; i < NI; i++) m_wr[i] = '0;
                        m_wr[0] = host_din;
                        m_cnt   = 1;
                        m_state = 2;
                    end
                end
                1: begin
                    void'(m_rdq.pop_front());
                    if (m_rdq.size() == 0) begin
                        m_state = 0;
                        nd = 1'b1;
                    end
                end
                2: begin
                    m_wr[m_cnt] = host_din;
                    m_cnt++;
                    if (m_cnt == m_len) m_state = 3;
                end
                default: begin
                    m_state = 0;
                    nd = 1'b1;
                end
            endcase
        end
        m_done = nd;
    endtask

    task automatic compare();
        logic [NI-1:0]    e_oe;
        logic [NI*PW-1:0] e_wd;
        e_oe = '0;
        e_wd = '0;
        if (m_state == 3) begin
            e_oe = (m_len == 2) ? 4'b0011 : 4'b1111;
            for (int i = 0; i < m_len; i++) e_wd[i*PW +: PW] = m_wr[i];
        end
        check("host_oe R3 R8", {143'b0, host_oe}, {143'b0, (m_state == 1)});
        if (m_state == 1)
            check("host_dout R3", {108'b0, host_dout}, {108'b0, m_rdq[0]});
        check("dram_oe R5 R6 R8", {140'b0, dram_oe}, {140'b0, e_oe});
        if (m_state == 3) check("dram_wr_data R5 R6", dram_wr_data, e_wd);
        check("wr_ready R5", {143'b0, wr_ready}, {143'b0, (m_state == 3)});
        check("burst_done R9", {143'b0, burst_done}, {143'b0, m_done});
        check("one side R7", {143'b0, (host_oe && |dram_oe)}, '0);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #2;
        compare();
    endtask

    function automatic logic [NI*PW-1:0] pattern(input int seed);
        logic [NI*PW-1:0] v;
        for (int i = 0; i < NI; i++)
            v[i*PW +: PW] = {4'(seed), 4'(i), 10'(seed * 7 + i), 4'(i + 8), 4'(seed), 10'(i * 33 + seed)};
        return v;
    endfunction

    task automatic read_burst(input logic tw, input int seed, input bit churn);
        two_way_mode = tw; dir_write = 1'b0; start = 1'b1;
        dram_rd_data = pattern(seed);
        step();
        start = 1'b0;
        for (int c = 0; c < (tw ? 2 : 4); c++) begin
            if (churn) dram_rd_data = pattern(seed + 100 + c);
            step();
        end
    endtask

    task automatic write_burst(input logic tw, input int seed);
        logic [NI*PW-1:0] p;
        p = pattern(seed);
        two_way_mode = tw; dir_write = 1'b1; start = 1'b1;
        for (int c = 0; c < (tw ? 2 : 4); c++) begin
            host_din = p[c*PW +: PW];
            step();
            start = 1'b0;
        end
        step();
    endtask

    bit finished = 0;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung exp done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; two_way_mode = 1'b0; dir_write = 1'b0; start = 1'b0;
        dram_rd_data = '0; host_din = '0;
        // R1: reset state, including a start held during reset
        cur_req = "R1";
        start = 1'b1;
        for (int c = 0; c < 3; c++) step();
        start = 1'b0; rst = 1'b0;
        step();
        // R8: idle with changing inputs
        cur_req = "R8";
        for (int c = 0; c < 3; c++) begin
            dram_rd_data = pattern(c + 40); host_din = 36'(c * 5 + 1); step();
        end
        // R2 R3: 4-way read, DRAM inputs changing after the capture
        cur_req = "R2 R3";
        read_burst(1'b0, 1, 1'b1);
        step();
        // R4: 2-way read
        cur_req = "R4";
        read_burst(1'b1, 2, 1'b1);
        step();
        // R5: 4-way write
        cur_req = "R5";
        write_burst(1'b0, 3);
        step();
        // R6: 2-way write
        cur_req = "R6";
        write_burst(1'b1, 4);
        step();
        // R10: start held high through a read, a new start on the done cycle
        cur_req = "R10";
        two_way_mode = 1'b0; dir_write = 1'b0; start = 1'b1; dram_rd_data = pattern(5);
        for (int c = 0; c < 9; c++) begin
            dram_rd_data = pattern(6 + c); step();
        end
        start = 1'b0;
        for (int c = 0; c < 5; c++) step();
        // R10: start during a write
        two_way_mode = 1'b0; dir_write = 1'b1; start = 1'b1;
        for (int c = 0; c < 6; c++) begin
            host_din = 36'(c * 1111 + 9); step();
            if (c == 0) start = 1'b0;
            if (c == 2) start = 1'b1;
        end
        start = 1'b0;
        for (int c = 0; c < 6; c++) step();
        // R11: mode and direction toggled during bursts
        cur_req = "R11";
        two_way_mode = 1'b0; dir_write = 1'b0; start = 1'b1; dram_rd_data = pattern(20);
        step();
        start = 1'b0; two_way_mode = 1'b1; dir_write = 1'b1;
        for (int c = 0; c < 5; c++) step();
        two_way_mode = 1'b1; dir_write = 1'b1; start = 1'b1; host_din = 36'h123456789;
        step();
        start = 1'b0; two_way_mode = 1'b0; dir_write = 1'b0; host_din = 36'h0abcdef01;
        for (int c = 0; c < 4; c++) step();
        // R7 R9: randomized mix
        cur_req = "R7 R9";
        for (int k = 0; k < 60; k++) begin
            two_way_mode = 1'($urandom);
            dir_write    = 1'($urandom);
            start        = ($urandom % 3) != 0;
            dram_rd_data = {$urandom, $urandom, $urandom, $urandom, $urandom}[NI*PW-1:0];
            host_din     = {$urandom, $urandom}[PW-1:0];
            step();
        end
        start = 1'b0;
        for (int c = 0; c < 6; c++) step();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule